// File: doc/BRIEF.md
# Eight-bit timer/counter with synchronised prescaled input

The block is an 8-bit up-counter that runs from one of two sources. In timer mode it advances once per instruction cycle, where one instruction cycle is four clock periods. In counter mode it counts transitions on an external pin, and a control bit picks which edge counts. An 8-stage binary prescaler can be placed between the source and the counter, or it can be bypassed. Whatever reaches the counter passes through a synchroniser. The synchroniser samples the prescaler output on two fixed phases of the four-phase instruction cycle. The increment therefore lands a few clocks after the qualifying edge, not at the edge itself. When an increment wraps the count from 0xFF to 0x00, a sticky overflow flag is set.

Software-style control comes through two write ports. One loads an 8-bit option register. The other loads the count. Loading the count also empties the prescaler and suppresses counting for the following two instruction cycles.

A four-state phase sequencer drives the sampling. It has the states PH_Q1, PH_Q2, PH_Q3 and PH_Q4. Reset places it in PH_Q1, and on every clock it moves Q1→Q2, Q2→Q3, Q3→Q4 and Q4→Q1. The sample strobe is active in PH_Q2 and PH_Q4. The internal instruction-cycle level is high in PH_Q1 and PH_Q2.

Top module: `pulse_timer8`

## Requirements
- R1: After reset the option register reads 0xFF, the count reads 0x00 and the overflow flag is 0.
- R2: With option bit 5 = 0 (internal source) and bit 3 = 1 (prescaler bypassed), the count advances by exactly one every 4 clocks.
- R3: With option bit 5 = 1 (external pin), bit 4 selects the counted edge. When bit 4 = 0, a rising pin edge advances the count while the pin is still high. When bit 4 = 1, the count waits for the falling edge.
- R4: With option bit 3 = 0, the prescaler counts source edges. Option bits 2:0 = k select prescaler stage k, which gives a divide ratio of 2^(k+1), from 2 up to 256. After E edges that follow a cleared prescaler, the count has advanced by floor((E + 2^k) / 2^(k+1)).
- R5: With option bit 3 = 1, every qualifying external edge advances the count by one, whatever bits 2:0 hold.
- R6: The pin is registered on every clock edge. That register is sampled on the 2nd, 4th, 6th, and every later even edge after reset release. A high level that the input register holds only between an even edge and the next odd edge is not counted. A level held for two clocks is always counted.
- R7: A count write loads the written value at the next edge and clears the prescaler stages.
- R8: For the 8 clock edges after the edge that takes a count write, no increment occurs.
- R9: An increment from 0xFF to 0x00 sets the overflow flag. The flag stays set until `ovf_clr` is asserted. If a set and a clear occur in the same cycle, the set wins.
- R10: An option write stores all 8 bits, and `opt_q` shows them from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; four periods form one instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External count input |
| opt_wr | input | 1 | Option register write strobe |
| opt_wdata | input | 8 | Option value: [5] external source, [4] falling edge, [3] bypass prescaler, [2:0] prescale stage |
| opt_q | output | 8 | Current option register |
| tmr_wr | input | 1 | Count write strobe |
| tmr_wdata | input | 8 | Count value to load |
| tmr_q | output | 8 | Current count |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A wrong prescaler stage or a missed clear shows up at `tmr_q` as a final count that differs from the floor formula. It becomes visible within a single batch of pulses, or, for the clear, within one further edge. A sampling phase that is off by one clock shows up only with one-clock pulses placed at a known parity after reset: such a pulse is counted when it should be dropped, and the error is visible about four clocks later. A broken write inhibit or overflow path shows up within eight clocks of the write, or in the cycle of the wrap.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int RATE_W = 3;
    localparam int OPT_W  = 8;

    typedef struct packed {
        logic [1:0]        spare;
        logic              ext_src;
        logic              fall_edge;
        logic              pre_bypass;
        logic [RATE_W-1:0] rate;
    } opt_t;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_t;

endpackage

// File: rtl/ptmr_phase_seq.sv
module ptmr_phase_seq
    import ptmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic samp_stb,
    output logic icyc_hi
);

    phase_t st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PH_Q1;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            PH_Q1: st_nx = PH_Q2;
            PH_Q2: st_nx = PH_Q3;
            PH_Q3: st_nx = PH_Q4;
            PH_Q4: st_nx = PH_Q1;
        endcase
    end

    // sampling strobe on Q2/Q4; instruction-cycle level high in first half
    always_comb begin
        samp_stb = 1'b0;
        icyc_hi  = 1'b0;
        unique case (st)
            PH_Q1: icyc_hi = 1'b1;
            PH_Q2: begin
                icyc_hi  = 1'b1;
                samp_stb = 1'b1;
            end
            PH_Q3: icyc_hi = 1'b0;
            PH_Q4: samp_stb = 1'b1;
        endcase
    end

endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src,
    input  logic              clr,
    input  logic              bypass,
    input  logic [RATE_W-1:0] rate,
    output logic              pout
);

    localparam int PRE_W = 1 << RATE_W;

    logic             src_d;
    logic [PRE_W-1:0] stages;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_d  <= 1'b0;
            stages <= '0;
        end else begin
            src_d <= src;
            if (clr)
                stages <= '0;
            else if (!bypass && src && !src_d)
                stages <= stages + PRE_W'(1);
        end
    end

    // stage k toggles at half the rate of stage k-1: ratio 2^(k+1)
    assign pout = bypass ? src : stages[rate];

endmodule

// File: rtl/ptmr_sync.sv
module ptmr_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic samp_stb,
    input  logic din,
    output logic inc_pulse
);

    logic smp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp       <= 1'b0;
            inc_pulse <= 1'b0;
        end else begin
            inc_pulse <= samp_stb && din && !smp;
            if (samp_stb) smp <= din;
        end
    end

endmodule

// File: rtl/pulse_timer8.sv
module pulse_timer8
    import ptmr_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int INHIBIT_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_pin,
    input  logic             opt_wr,
    input  logic [OPT_W-1:0] opt_wdata,
    output logic [OPT_W-1:0] opt_q,
    input  logic             tmr_wr,
    input  logic [CNT_W-1:0] tmr_wdata,
    output logic [CNT_W-1:0] tmr_q,
    input  logic             ovf_clr,
    output logic             ovf_flag
);

    localparam int INH_CLKS = INHIBIT_CYC * 4;
    localparam int INH_W    = $clog2(INH_CLKS + 1);

    opt_t             opt;
    logic             pin_r;
    logic             src;
    logic             samp_stb;
    logic             icyc_hi;
    logic             pre_out;
    logic             inc_pulse;
    logic [INH_W-1:0] inh;
    logic             inc_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opt   <= '1;
            pin_r <= 1'b0;
        end else begin
            pin_r <= ext_pin;
            if (opt_wr) opt <= opt_t'(opt_wdata);
        end
    end

    assign opt_q = opt;
    assign src   = opt.ext_src ? (pin_r ^ opt.fall_edge) : icyc_hi;

    ptmr_phase_seq u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .samp_stb (samp_stb),
        .icyc_hi  (icyc_hi)
    );

    ptmr_prescaler #(.RATE_W(RATE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (src),
        .clr    (tmr_wr),
        .bypass (opt.pre_bypass),
        .rate   (opt.rate),
        .pout   (pre_out)
    );

    ptmr_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_stb  (samp_stb),
        .din       (pre_out),
        .inc_pulse (inc_pulse)
    );

    assign inc_ok = inc_pulse && (inh == '0) && !tmr_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q    <= '0;
            inh      <= '0;
            ovf_flag <= 1'b0;
        end else begin
            if (tmr_wr) begin
                tmr_q <= tmr_wdata;
                inh   <= INH_W'(INH_CLKS);
            end else begin
                if (inc_ok)     tmr_q <= tmr_q + CNT_W'(1);
                if (inh != '0)  inh   <= inh - INH_W'(1);
            end
            if (inc_ok && (tmr_q == '1)) ovf_flag <= 1'b1;
            else if (ovf_clr)            ovf_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/pulse_timer8_chk.sv
module pulse_timer8_chk #(
    parameter int CNT_W       = 8,
    parameter int INHIBIT_CYC = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             opt_wr,
    input logic [7:0]       opt_wdata,
    input logic [7:0]       opt_q,
    input logic             tmr_wr,
    input logic [CNT_W-1:0] tmr_wdata,
    input logic [CNT_W-1:0] tmr_q,
    input logic             ovf_clr,
    input logic             ovf_flag
);

    localparam int WIN   = INHIBIT_CYC * 4;
    localparam int WIN_W = $clog2(WIN + 1);

    logic [WIN_W-1:0] win;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          win <= '0;
        else if (tmr_wr)     win <= WIN_W'(WIN);
        else if (win != '0)  win <= win - WIN_W'(1);
    end

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_wr |=> (tmr_q == $past(tmr_q)) || (tmr_q == $past(tmr_q) + CNT_W'(1)));

    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wr |=> tmr_q == $past(tmr_wdata));

    p_inhibit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (win != '0 && !tmr_wr) |=> tmr_q == $past(tmr_q));

    p_wrap_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q == '1 && !tmr_wr) |=> (tmr_q != '0) || ovf_flag);

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    p_flag_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (tmr_q == '0) && ($past(tmr_q) == '1));

    p_opt_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        opt_wr |=> opt_q == $past(opt_wdata));

    p_opt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !opt_wr |=> $stable(opt_q));

endmodule

bind pulse_timer8 pulse_timer8_chk #(
    .CNT_W       (CNT_W),
    .INHIBIT_CYC (INHIBIT_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opt_wr    (opt_wr),
    .opt_wdata (opt_wdata),
    .opt_q     (opt_q),
    .tmr_wr    (tmr_wr),
    .tmr_wdata (tmr_wdata),
    .tmr_q     (tmr_q),
    .ovf_clr   (ovf_clr),
    .ovf_flag  (ovf_flag)
);

// File: tb/pulse_timer8_test.sv
module pulse_timer8_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 1'b0;
    logic       opt_wr = 1'b0;
    logic [7:0] opt_wdata = 8'h00;
    logic [7:0] opt_q;
    logic       tmr_wr = 1'b0;
    logic [7:0] tmr_wdata = 8'h00;
    logic [7:0] tmr_q;
    logic       ovf_clr = 1'b0;
    logic       ovf_flag;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit ended = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    pulse_timer8 uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_pin   (ext_pin),
        .opt_wr    (opt_wr),
        .opt_wdata (opt_wdata),
        .opt_q     (opt_q),
        .tmr_wr    (tmr_wr),
        .tmr_wdata (tmr_wdata),
        .tmr_q     (tmr_q),
        .ovf_clr   (ovf_clr),
        .ovf_flag  (ovf_flag)
    );

    // {rate[2:0], bypass, edges[15:0], expected[7:0]}
    localparam int NVEC = 9;
    localparam logic [27:0] VEC [NVEC] = '{
        {3'd0, 1'b0, 16'd300, 8'd150},
        {3'd1, 1'b0, 16'd300, 8'd75},
        {3'd2, 1'b0, 16'd300, 8'd38},
        {3'd3, 1'b0, 16'd300, 8'd19},
        {3'd4, 1'b0, 16'd300, 8'd9},
        {3'd5, 1'b0, 16'd300, 8'd5},
        {3'd6, 1'b0, 16'd300, 8'd2},
        {3'd7, 1'b0, 16'd300, 8'd1},
        {3'd5, 1'b1, 16'd300, 8'd44}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic set_opt(input logic [7:0] v);
        @(negedge clk); opt_wr = 1'b1; opt_wdata = v;
        @(negedge clk); opt_wr = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic wr_tmr(input logic [7:0] v);
        @(negedge clk); tmr_wr = 1'b1; tmr_wdata = v;
        @(negedge clk); tmr_wr = 1'b0;
    endtask

    task automatic pulses(input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) begin
            ext_pin = 1'b1;
            repeat (hi) @(negedge clk);
            ext_pin = 1'b0;
            repeat (lo) @(negedge clk);
        end
    endtask

    task automatic clear_flag();
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] a;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 opt", opt_q, 8'hFF);
        check("R1 count", tmr_q, 8'h00);
        check("R1 flag", {7'd0, ovf_flag}, 8'h00);

        // R4/R5 table: external rising edges, period 8 clocks
        for (int v = 0; v < NVEC; v++) begin
            set_opt({2'b00, 1'b1, 1'b0, VEC[v][24], VEC[v][27:25]});
            wr_tmr(8'h00);
            repeat (10) @(negedge clk);
            pulses(int'(VEC[v][23:8]), 4, 4);
            repeat (20) @(negedge clk);
            check(VEC[v][24] ? "R5 bypass count" : "R4 prescaled count", tmr_q, VEC[v][7:0]);
        end

        // R2 timer mode, prescaler bypassed: one step per 4 clocks
        set_opt(8'b00_0_0_1_000);
        wr_tmr(8'h00);
        repeat (20) @(negedge clk);
        a = tmr_q;
        repeat (40) @(negedge clk);
        check("R2 timer step", tmr_q - a, 8'd10);
        // R4 timer mode with divide-by-2
        set_opt(8'b00_0_0_0_000);
        wr_tmr(8'h00);
        repeat (20) @(negedge clk);
        a = tmr_q;
        repeat (80) @(negedge clk);
        check("R4 timer div2", tmr_q - a, 8'd10);

        // R8 inhibit after write (timer mode, bypass)
        set_opt(8'b00_0_0_1_000);
        wr_tmr(8'h50);
        repeat (7) @(negedge clk);
        check("R8 hold", tmr_q, 8'h50);
        repeat (12) @(negedge clk);
        check("R8 resumes", {7'd0, tmr_q > 8'h50}, 8'd1);

        // R3 rising edge select
        set_opt(8'b00_1_0_1_000);
        wr_tmr(8'h00);
        repeat (10) @(negedge clk);
        ext_pin = 1'b1;
        repeat (12) @(negedge clk);
        check("R3 rise on high", tmr_q, 8'd1);
        ext_pin = 1'b0;
        repeat (12) @(negedge clk);
        check("R3 rise after low", tmr_q, 8'd1);
        // R3 falling edge select
        set_opt(8'b00_1_1_1_000);
        wr_tmr(8'h00);
        repeat (10) @(negedge clk);
        ext_pin = 1'b1;
        repeat (12) @(negedge clk);
        check("R3 fall on high", tmr_q, 8'd0);
        ext_pin = 1'b0;
        repeat (12) @(negedge clk);
        check("R3 fall after low", tmr_q, 8'd1);

        // R6 narrow pulse rejection and two-clock acceptance
        set_opt(8'b00_1_0_1_000);
        wr_tmr(8'h00);
        repeat (10) @(negedge clk);
        while (cyc % 2 == 0) @(negedge clk);
        ext_pin = 1'b1;
        @(negedge clk);
        ext_pin = 1'b0;
        repeat (12) @(negedge clk);
        check("R6 narrow ignored", tmr_q, 8'd0);
        while (cyc % 2 == 0) @(negedge clk);
        ext_pin = 1'b1;
        repeat (2) @(negedge clk);
        ext_pin = 1'b0;
        repeat (12) @(negedge clk);
        check("R6 two-clock seen", tmr_q, 8'd1);

        // R7 write clears prescaler (divide by 4)
        set_opt(8'b00_1_0_0_001);
        wr_tmr(8'h00);
        repeat (10) @(negedge clk);
        pulses(1, 4, 4);
        wr_tmr(8'h00);
        repeat (10) @(negedge clk);
        pulses(1, 4, 4);
        repeat (20) @(negedge clk);
        check("R7 prescaler cleared", tmr_q, 8'd0);
        pulses(1, 4, 4);
        repeat (20) @(negedge clk);
        check("R7 second edge", tmr_q, 8'd1);
        wr_tmr(8'hA5);
        check("R7 load", tmr_q, 8'hA5);

        // R9 overflow flag
        set_opt(8'b00_1_0_1_000);
        wr_tmr(8'hFE);
        clear_flag();
        check("R9 cleared", {7'd0, ovf_flag}, 8'd0);
        repeat (10) @(negedge clk);
        pulses(1, 4, 4);
        repeat (12) @(negedge clk);
        check("R9 at FF", tmr_q, 8'hFF);
        check("R9 no flag yet", {7'd0, ovf_flag}, 8'd0);
        pulses(1, 4, 4);
        repeat (12) @(negedge clk);
        check("R9 wrap", tmr_q, 8'h00);
        check("R9 flag set", {7'd0, ovf_flag}, 8'd1);
        pulses(1, 4, 4);
        repeat (12) @(negedge clk);
        check("R9 flag sticky", {7'd0, ovf_flag}, 8'd1);
        clear_flag();
        check("R9 flag clear", {7'd0, ovf_flag}, 8'd0);

        // R10 option readback
        set_opt(8'h3C);
        check("R10 opt", opt_q, 8'h3C);

        finish_run();
    end

endmodule